// File: doc/BRIEF.md
# Program Counter Flow Sequencer

This block owns the instruction address of a small 16-bit controller core. Each time the core's valid strobe is high at a rising clock edge, the program counter moves to its next value. By default the next value is the current address plus one, and that value is always held ready in a dedicated register. When the decoder marks the current instruction as a control instruction, a 2-bit function selects one of four operations: a conditional jump, an unconditional jump, a call or a return.

A conditional jump tests one of eight conditions against a four-bit flag word. The flags are sign, overflow, zero and carry, as left behind by an earlier compare. The tests cover equality and the signed orderings, plus the overflow flag alone. A call saves the incremented address in a single link register before it jumps. A return resumes from that register. There is no call stack, so a second call replaces the saved address.

Top module: `pcf_flow_seq`

## Requirements
- R1: After reset `pc_o` is 0 and the link register is 0, so a return issued as the first step leads to address 0.
- R2: While `step_i` is low, `pc_o` holds its value whatever the other inputs are.
- R3: A step with `ctl_i` low sets `pc_o` to the previous address plus one, modulo 2^ADDR_W (0xFFFF goes to 0).
- R4: A step with `ctl_i` high and `func_i`=01 (unconditional jump) sets `pc_o` to `target_i`.
- R5: A step with `ctl_i` high and `func_i`=10 (call) sets `pc_o` to `target_i` and stores the previous address plus one in the link register.
- R6: A step with `ctl_i` high and `func_i`=11 (return) sets `pc_o` to the link register. A later call overwrites the link, so only the most recent call is returned to.
- R7: With `func_i`=00 (conditional jump), `cond_i`=000 is taken when ZF (`flags_i[1]`) is 1, and `cond_i`=001 is taken when ZF is 0.
- R8: `cond_i`=010 (signed greater-or-equal) is taken when SF (`flags_i[3]`) equals OF (`flags_i[2]`), and `cond_i`=101 (signed less) is taken when they differ.
- R9: `cond_i`=100 (signed greater) is taken when ZF is 0 and SF equals OF. `cond_i`=011 (signed less-or-equal) is taken when ZF is 1 or SF differs from OF.
- R10: `cond_i`=110 is taken when OF is 1, and `cond_i`=111 is taken when OF is 0.
- R11: A taken conditional jump sets `pc_o` to `target_i`. A conditional jump that is not taken sets `pc_o` to the previous address plus one.
- R12: CF (`flags_i[0]`) has no effect on any condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Valid strobe; the address advances on an edge where it is high |
| ctl_i | input | 1 | Current instruction is a control instruction |
| func_i | input | 2 | Control function: 00 conditional, 01 jump, 10 call, 11 return |
| cond_i | input | 3 | Condition code for a conditional jump |
| target_i | input | ADDR_W | Jump or call destination |
| flags_i | input | 4 | {SF, OF, ZF, CF} |
| pc_o | output | ADDR_W | Current instruction address |

## Verification
Every condition code is tried with all sixteen flag words. The target differs on each trial, so a taken jump can always be told apart from a fall-through to the next address. The sweep shows whether each signed test reads the right mix of sign, overflow and zero. Pairs that differ only in the carry bit show that carry is ignored. Call and return sequences are run with a second call placed before the return, which separates a correct single link register from one that is never overwritten. Jumps to the top address followed by a plain step exercise the wrap to zero.

// File: rtl/pcf_pkg.sv
package pcf_pkg;
   typedef enum logic [1:0] {
      FN_BRCOND = 2'b00,
      FN_JUMP   = 2'b01,
      FN_CALL   = 2'b10,
      FN_RET    = 2'b11
   } flow_fn_e;

   localparam int FLAG_W  = 4;
   localparam int COND_W  = 3;
   localparam int FLAG_SF = 3;
   localparam int FLAG_OF = 2;
   localparam int FLAG_ZF = 1;
   localparam int FLAG_CF = 0;
endpackage

// File: rtl/pcf_cond_eval.sv
module pcf_cond_eval
   import pcf_pkg::*;
#(
   parameter int CW = COND_W
) (
   input  logic          sf_i,
   input  logic          of_i,
   input  logic          zf_i,
   input  logic [CW-1:0] cond_i,
   output logic          hit_o
);
   localparam int NCOND = 1 << CW;

   logic [NCOND-1:0] cond_vec;
   logic             sgn_lt;

   initial assert (CW == 3) else $error("pcf_cond_eval: eight conditions need a 3-bit code");

   assign sgn_lt = sf_i ^ of_i;

   for (genvar i = 0; i < NCOND; i++) begin : g_cond
      if (i == 0) begin : g_eq
         assign cond_vec[i] = zf_i;
      end else if (i == 1) begin : g_ne
         assign cond_vec[i] = !zf_i;
      end else if (i == 2) begin : g_ge
         assign cond_vec[i] = !sgn_lt;
      end else if (i == 3) begin : g_le
         assign cond_vec[i] = zf_i | sgn_lt;
      end else if (i == 4) begin : g_gt
         assign cond_vec[i] = !zf_i & !sgn_lt;
      end else if (i == 5) begin : g_lt
         assign cond_vec[i] = sgn_lt;
      end else if (i == 6) begin : g_ov
         assign cond_vec[i] = of_i;
      end else begin : g_nov
         assign cond_vec[i] = !of_i;
      end
   end

   assign hit_o = cond_vec[cond_i];
endmodule

// File: rtl/pcf_next_reg.sv
module pcf_next_reg #(
   parameter int AW = 16,
   parameter logic [AW-1:0] RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] val_i,
   output logic [AW-1:0] pc_q,
   output logic [AW-1:0] inc_q
);
   localparam logic [AW-1:0] ONE = AW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= RST_VAL;
         inc_q <= RST_VAL + ONE;
      end else if (load_i) begin
         pc_q  <= val_i;
         inc_q <= val_i + ONE;
      end
   end
endmodule

// File: rtl/pcf_link_reg.sv
module pcf_link_reg #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_i,
   input  logic [AW-1:0] d_i,
   output logic [AW-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= '0;
      else if (wr_i) q_o <= d_i;
   end
endmodule

// File: rtl/pcf_flow_seq.sv
module pcf_flow_seq
   import pcf_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic              ctl_i,
   input  logic [1:0]        func_i,
   input  logic [COND_W-1:0] cond_i,
   input  logic [ADDR_W-1:0] target_i,
   input  logic [FLAG_W-1:0] flags_i,
   output logic [ADDR_W-1:0] pc_o
);
   logic [ADDR_W-1:0] pc_q, inc_q, link_q, nxt_pc;
   logic              hit, link_we;
   logic              unused_cf;
   flow_fn_e          fn;

   initial assert (ADDR_W >= 2 && ADDR_W <= 32)
      else $error("pcf_flow_seq: ADDR_W out of range");

   assign fn        = flow_fn_e'(func_i);
   assign unused_cf = flags_i[FLAG_CF];

   pcf_cond_eval #(.CW(COND_W)) u_cond (
      .sf_i  (flags_i[FLAG_SF]),
      .of_i  (flags_i[FLAG_OF]),
      .zf_i  (flags_i[FLAG_ZF]),
      .cond_i(cond_i),
      .hit_o (hit)
   );

   always_comb begin
      nxt_pc  = inc_q;
      link_we = 1'b0;
      if (ctl_i) begin
         unique case (fn)
            FN_BRCOND: if (hit) nxt_pc = target_i;
            FN_JUMP:   nxt_pc = target_i;
            FN_CALL: begin
               nxt_pc  = target_i;
               link_we = 1'b1;
            end
            FN_RET:    nxt_pc = link_q;
            default:   nxt_pc = inc_q;
         endcase
      end
   end

   pcf_next_reg #(.AW(ADDR_W)) u_pc (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(step_i),
      .val_i (nxt_pc),
      .pc_q  (pc_q),
      .inc_q (inc_q)
   );

   pcf_link_reg #(.AW(ADDR_W)) u_link (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_i (step_i & link_we),
      .d_i  (inc_q),
      .q_o  (link_q)
   );

   assign pc_o = pc_q;
endmodule

// File: rtl/pcf_flow_chk.sv
module pcf_flow_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              step_i,
   input logic              ctl_i,
   input logic [1:0]        func_i,
   input logic [2:0]        cond_i,
   input logic [ADDR_W-1:0] target_i,
   input logic [3:0]        flags_i,
   input logic [ADDR_W-1:0] pc_o
);
   logic [ADDR_W-1:0] mdl_link;
   logic              br;

   assign br = step_i && ctl_i && func_i == 2'b00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mdl_link <= '0;
      else if (step_i && ctl_i && func_i == 2'b10) mdl_link <= pc_o + ADDR_W'(1);
   end

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> $stable(pc_o)); // R2
   AST_SEQ_INC: assert property (@(posedge clk) disable iff (!rst_n)
      step_i && !ctl_i |=> pc_o == $past(pc_o) + ADDR_W'(1)); // R3
   AST_JUMP_DST: assert property (@(posedge clk) disable iff (!rst_n)
      step_i && ctl_i && func_i == 2'b01 |=> pc_o == $past(target_i)); // R4
   AST_CALL_DST: assert property (@(posedge clk) disable iff (!rst_n)
      step_i && ctl_i && func_i == 2'b10 |=> pc_o == $past(target_i)); // R5
   AST_RET_LINK: assert property (@(posedge clk) disable iff (!rst_n)
      step_i && ctl_i && func_i == 2'b11 |=> pc_o == $past(mdl_link)); // R6
   AST_EQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      br && cond_i == 3'd0 && flags_i[1] |=> pc_o == $past(target_i)); // R7
   AST_LT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      br && cond_i == 3'd5 && (flags_i[3] != flags_i[2]) |=> pc_o == $past(target_i)); // R8
   AST_GT_ZERO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      br && cond_i == 3'd4 && flags_i[1] |=> pc_o == $past(pc_o) + ADDR_W'(1)); // R9
   AST_OV_CLEAR_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      br && cond_i == 3'd6 && !flags_i[2] |=> pc_o == $past(pc_o) + ADDR_W'(1)); // R10
endmodule

bind pcf_flow_seq pcf_flow_chk #(.ADDR_W(ADDR_W)) u_flow_chk (
   .clk(clk), .rst_n(rst_n), .step_i(step_i), .ctl_i(ctl_i), .func_i(func_i),
   .cond_i(cond_i), .target_i(target_i), .flags_i(flags_i), .pc_o(pc_o)
);

// File: tb/pcf_flow_seq_bench.sv
module pcf_flow_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_i = 1'b0, ctl_i = 1'b0;
   logic [1:0]  func_i = 2'b00;
   logic [2:0]  cond_i = 3'b000;
   logic [15:0] target_i = '0;
   logic [3:0]  flags_i = '0;
   logic [15:0] pc_o;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   typedef struct { logic [15:0] exp; string tag; } item_t;
   item_t sbq[$];

   logic [15:0] m_pc = '0, m_link = '0;

   always #10 clk = ~clk;

   pcf_flow_seq u_pcf_flow_seq (
      .clk(clk), .rst_n(rst_n), .step_i(step_i), .ctl_i(ctl_i), .func_i(func_i),
      .cond_i(cond_i), .target_i(target_i), .flags_i(flags_i), .pc_o(pc_o)
   );

   function automatic bit cond_true(logic [2:0] c, logic [3:0] f);
      bit s = f[3], o = f[2], z = f[1];
      case (c)
         3'd0: return z;
         3'd1: return !z;
         3'd2: return s == o;
         3'd3: return z || (s != o);
         3'd4: return !z && (s == o);
         3'd5: return s != o;
         3'd6: return o;
         default: return !o;
      endcase
   endfunction

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   task automatic drive(bit st, bit ctl, logic [1:0] fn, logic [2:0] cc,
                        logic [15:0] tgt, logic [3:0] fl, string tag);
      item_t it;
      @(negedge clk);
      step_i = st; ctl_i = ctl; func_i = fn; cond_i = cc; target_i = tgt; flags_i = fl;
      if (st) begin
         if (!ctl) m_pc = m_pc + 16'd1;
         else case (fn)
            2'b00: m_pc = cond_true(cc, fl) ? tgt : m_pc + 16'd1;
            2'b01: m_pc = tgt;
            2'b10: begin m_link = m_pc + 16'd1; m_pc = tgt; end
            default: m_pc = m_link;
         endcase
      end
      it.exp = m_pc; it.tag = tag;
      sbq.push_back(it);
   endtask

   initial begin : monitor
      item_t it;
      forever begin
         @(posedge clk);
         #2;
         if (sbq.size() > 0) begin
            it = sbq.pop_front();
            checks++;
            if (pc_o !== it.exp) begin
               fails++;
               $display("FAIL %s: pc_o actual %h expected %h", it.tag, pc_o, it.exp);
            end
         end
      end
   end

   initial begin : watchdog
      #(20 * 100000);
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      report();
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      checks++;
      if (pc_o !== 16'h0000) begin
         fails++;
         $display("FAIL R1: reset pc_o actual %h expected 0000", pc_o);
      end
      drive(1, 1, 2'b11, 3'd0, 16'h1234, 4'h0, "R1");
      for (int i = 0; i < 4; i++) drive(1, 0, 2'b01, 3'd0, 16'hBEEF, 4'hF, "R3");
      drive(0, 1, 2'b01, 3'd0, 16'h5555, 4'h0, "R2");
      drive(0, 0, 2'b10, 3'd0, 16'h7777, 4'h0, "R2");
      drive(1, 1, 2'b01, 3'd0, 16'hFFFF, 4'h0, "R4");
      drive(1, 0, 2'b00, 3'd0, 16'h0000, 4'h0, "R3");
      drive(1, 1, 2'b01, 3'd0, 16'h0100, 4'h0, "R4");
      drive(1, 1, 2'b10, 3'd0, 16'h0800, 4'h0, "R5");
      drive(1, 0, 2'b00, 3'd0, 16'h0000, 4'h0, "R3");
      drive(1, 1, 2'b11, 3'd0, 16'h0000, 4'h0, "R6");
      drive(1, 1, 2'b10, 3'd0, 16'h0900, 4'h0, "R5");
      drive(1, 1, 2'b10, 3'd0, 16'h0A00, 4'h0, "R5");
      drive(1, 1, 2'b11, 3'd0, 16'h0000, 4'h0, "R6");
      drive(1, 1, 2'b11, 3'd0, 16'h0000, 4'h0, "R6");
      for (int c = 0; c < 8; c++) begin
         for (int f = 0; f < 16; f++) begin
            string tg;
            case (c)
               0, 1: tg = "R7";
               2, 5: tg = "R8";
               3, 4: tg = "R9";
               default: tg = "R10";
            endcase
            if (!cond_true(3'(c), 4'(f))) tg = {tg, "/R11"};
            drive(1, 1, 2'b00, 3'(c), 16'h2000 + 16'(c * 64 + f * 2), 4'(f), tg);
         end
      end
      drive(1, 1, 2'b00, 3'd2, 16'h3000, 4'b0000, "R11");
      drive(1, 1, 2'b00, 3'd5, 16'h3100, 4'b0000, "R11");
      drive(1, 1, 2'b00, 3'd0, 16'h4000, 4'b0001, "R12");
      drive(1, 1, 2'b00, 3'd1, 16'h4100, 4'b0001, "R12");
      drive(1, 1, 2'b00, 3'd7, 16'h4200, 4'b0101, "R12");
      drive(1, 1, 2'b00, 3'd6, 16'h4300, 4'b0001, "R12");
      @(negedge clk);
      step_i = 1'b0;
      repeat (3) @(negedge clk);
      report();
   end
endmodule